// File: doc/BRIEF.md
# SPI Slave Pause Gate

This block sits between the raw pins of an SPI slave port and the shift engine behind it. It brings the serial clock, the active-low select, the active-low pause request and the serial data input into the system clock domain. From them it produces one-cycle strobes for the rising and falling serial clock edges and an enable for the serial data output. The shift engine advances only on these strobes. The engine keeps its bit counter and shift registers for the whole transfer and needs no pause logic of its own.

While the port is selected, the host may pull the pause input low in the middle of a byte. A pause takes hold only while the synchronized serial clock is low. A request made during the high phase waits for the next high-to-low clock transition. Release works the same way. While the port is paused, clock and data activity on the pins produces no strobes. When the pause ends, the next rising clock edge continues the same byte at the bit where it stopped. Deselecting the port always ends the transfer, even in the middle of a pause.

Top module: `spi_hold_gate`

## Requirements
- R1: While the select input is high (deselected), a low pause input never sets the `paused` output.
- R2: With the port selected and the synchronized clock low, a low pause input sets `paused` within four system clocks.
- R3: A pause request made while the clock is high leaves `paused` at 0 until the clock falls. The falling strobe for that transition is still delivered, and then `paused` becomes 1.
- R4: With the clock low, raising the pause input clears `paused` within four system clocks.
- R5: A release made while the clock is high keeps `paused` at 1 until the clock falls. No falling strobe is delivered for that transition.
- R6: While `paused` is 1, `sck_rise_en` and `sck_fall_en` stay 0, whatever the clock and data pins do.
- R7: `so_oe` is 0 whenever the synchronized pause input is low, the block is paused, or the port is deselected. A falling pause input drops `so_oe` at once, even during the clock high phase.
- R8: Raising the select input clears `paused` and `selected`.
- R9: A byte sent MSB first, with any single pause inserted in either phase, yields exactly 8 rising and 8 falling strobes. The 8 bits sampled on the rising strobes equal the byte sent.
- R10: After reset, `paused`, `selected`, `so_oe` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| cs_n_pin | input | 1 | Active-low select pin, asynchronous |
| hold_n_pin | input | 1 | Active-low pause pin, asynchronous |
| si_pin | input | 1 | Serial data input pin, asynchronous |
| si_data | output | 1 | Serial data input, synchronized and aligned with the strobes |
| sck_rise_en | output | 1 | One-cycle strobe for a rising clock edge the engine should take |
| sck_fall_en | output | 1 | One-cycle strobe for a falling clock edge the engine should take |
| so_oe | output | 1 | Output enable for the serial data output driver |
| selected | output | 1 | Synchronized select, high while the port is addressed |
| paused | output | 1 | Pause flag |

## Verification
A deferred pause entry and a falling clock edge land in the same system cycle. The falling strobe must be delivered while `paused` rises. A deferred release and a falling edge also share a cycle, and there the strobe must be withheld while `paused` falls. Both cases are provoked by moving the pause pin during the clock high phase and then lowering the clock. The bench drives garbage clock and data while paused. It judges the outcome by the strobe counts and the received byte at the end of each transfer.

// File: rtl/spi_hold_pkg.sv
// Package: shared pin-vector layout for the pause gate.
// Assumes all four pins are synchronized as one vector.
package spi_hold_pkg;
    localparam int PIN_W    = 4;
    localparam int PIN_SCK  = 0;
    localparam int PIN_CSN  = 1;
    localparam int PIN_HLDN = 2;
    localparam int PIN_SI   = 3;
    typedef logic [PIN_W-1:0] pin_vec_t;
    // Idle levels: select and pause inactive (high), clock and data low.
    localparam pin_vec_t PIN_IDLE = pin_vec_t'((1 << PIN_CSN) | (1 << PIN_HLDN));
endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchronizer, one independent chain per bit.
// Assumes each bit is a slow level compared with clk; bits are not coherent.
module pin_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sck_edge.sv
// Rising and falling edge detection on the synchronized serial clock.
// Assumes the clock input is already in the clk domain.
module sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    output logic rise,
    output logic fall
);
    logic sck_d;
    // Remember the previous clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end
    assign rise = sck_s & ~sck_d;
    assign fall = ~sck_s & sck_d;
endmodule

// File: rtl/hold_pause_ctl.sv
// Pause flag and strobe gating.
// Entry and exit happen only while the clock is low. A request made during
// the high phase therefore takes effect on the falling edge. The falling
// strobe that ends a high phase goes to the engine only if the port was not
// paused. So the engine always sees alternating rise and fall strobes.
module hold_pause_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    input  logic hold_n_s,
    input  logic rise,
    input  logic fall,
    output logic paused,
    output logic rise_en,
    output logic fall_en,
    output logic so_oe,
    output logic selected
);
    logic enter, leave;

    assign selected = ~cs_n_s;
    assign enter    = selected & ~paused & ~hold_n_s & ~sck_s;
    assign leave    = paused & hold_n_s & ~sck_s;

    // Pause flag: cleared by deselection, moved only during the clock low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      paused <= 1'b0;
        else if (cs_n_s) paused <= 1'b0;
        else if (enter)  paused <= 1'b1;
        else if (leave)  paused <= 1'b0;
    end

    assign rise_en = rise & selected & ~paused;
    assign fall_en = fall & selected & ~paused;
    assign so_oe   = selected & ~paused & hold_n_s;
endmodule

// File: rtl/spi_hold_gate.sv
// Top level: synchronizes the pins, finds clock edges and gates them by the
// pause state. Assumes the pins change slowly compared with clk (several
// system clocks per serial clock phase).
module spi_hold_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic hold_n_pin,
    input  logic si_pin,
    output logic si_data,
    output logic sck_rise_en,
    output logic sck_fall_en,
    output logic so_oe,
    output logic selected,
    output logic paused
);
    import spi_hold_pkg::*;

    pin_vec_t pins_raw, pins_s;
    logic sck_s, cs_n_s, hold_n_s;
    logic rise, fall;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCK]  = sck_pin;
        pins_raw[PIN_CSN]  = cs_n_pin;
        pins_raw[PIN_HLDN] = hold_n_pin;
        pins_raw[PIN_SI]   = si_pin;
    end

    pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    assign sck_s    = pins_s[PIN_SCK];
    assign cs_n_s   = pins_s[PIN_CSN];
    assign hold_n_s = pins_s[PIN_HLDN];
    assign si_data  = pins_s[PIN_SI];

    sck_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .rise(rise), .fall(fall)
    );

    hold_pause_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
        .hold_n_s(hold_n_s), .rise(rise), .fall(fall), .paused(paused),
        .rise_en(sck_rise_en), .fall_en(sck_fall_en), .so_oe(so_oe),
        .selected(selected)
    );
endmodule

// File: rtl/spi_hold_gate_chk.sv
// Checker for the pause gate, bound to the top level. It watches the
// synchronized pins and the outputs.
module spi_hold_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_s,
    input logic cs_n_s,
    input logic hold_n_s,
    input logic sck_rise_en,
    input logic sck_fall_en,
    input logic so_oe,
    input logic paused
);
    // R2 / R3: the pause starts only from a low clock with the pause input low.
    a_r2_enter_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> ($past(!sck_s) && $past(!hold_n_s) && $past(!cs_n_s)));

    // R4 / R5 / R8: the pause ends only on release during a low clock, or on deselect.
    a_r4_exit_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> (($past(hold_n_s) && $past(!sck_s)) || $past(cs_n_s)));

    // R8: deselection clears the flag.
    a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !paused);

    // R6: no strobes reach the engine while paused.
    a_r6_no_strobe_paused: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> (!sck_rise_en && !sck_fall_en));

    // R7: the output driver is off whenever the pause input is low or the port is idle.
    a_r7_so_off: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (hold_n_s && !cs_n_s && !paused));

    // R9: rise and fall strobes are never given in the same cycle.
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sck_rise_en, sck_fall_en}) <= 1);
endmodule

bind spi_hold_gate spi_hold_gate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
    .hold_n_s(hold_n_s), .sck_rise_en(sck_rise_en), .sck_fall_en(sck_fall_en),
    .so_oe(so_oe), .paused(paused)
);

// File: tb/test_spi_hold_gate.sv
module test_spi_hold_gate;
    localparam int HALF = 8;   // system clocks per serial clock phase
    localparam int SETL = 4;   // clocks for pins to pass sync and flag register
    localparam int NV   = 6;
    // Vector: {byte[7:0], pause bit[2:0], enter in high phase, exit in high phase}
    localparam logic [12:0] VEC [NV] = '{
        {8'hA5, 3'd3, 1'b0, 1'b0},
        {8'h3C, 3'd0, 1'b1, 1'b0},
        {8'hF0, 3'd7, 1'b0, 1'b1},
        {8'h81, 3'd5, 1'b1, 1'b1},
        {8'h00, 3'd1, 1'b1, 1'b0},
        {8'hFF, 3'd6, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
    logic si_data, rise_en, fall_en, so_oe, selected, paused;
    int n_chk = 0, n_bad = 0, cyc = 0;
    int rise_cnt = 0, fall_cnt = 0;
    logic [7:0] rx = '0;

    always #2 clk = ~clk;   // 250 MHz

    spi_hold_gate i_spi_hold_gate (
        .clk(clk), .rst_n(rst_n), .sck_pin(sck), .cs_n_pin(cs_n),
        .hold_n_pin(hold_n), .si_pin(si), .si_data(si_data),
        .sck_rise_en(rise_en), .sck_fall_en(fall_en), .so_oe(so_oe),
        .selected(selected), .paused(paused)
    );

    // Stand-in shift engine and strobe counters.
    always @(posedge clk) begin
        if (rise_en) begin rx <= {rx[6:0], si_data}; rise_cnt <= rise_cnt + 1; end
        if (fall_en) fall_cnt <= fall_cnt + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Garbage activity while paused, then release in the chosen phase. Ends with clock low.
    task automatic pause_body(input logic exit_hi);
        int r0, f0;
        r0 = rise_cnt; f0 = fall_cnt;
        for (int k = 0; k < 3; k++) begin
            si = k[0]; sck = 1'b1; wait_clk(HALF);
            si = ~k[0]; sck = 1'b0; wait_clk(HALF);
        end
        if (exit_hi) begin
            sck = 1'b1; wait_clk(HALF);
            hold_n = 1'b1; wait_clk(SETL);
            check("R5 release deferred in high phase", paused, 1);
            sck = 1'b0; wait_clk(SETL);
            check("R5 release at falling edge", paused, 0);
            wait_clk(HALF);
        end else begin
            hold_n = 1'b1; wait_clk(SETL);
            check("R4 release in low phase", paused, 0);
            wait_clk(HALF);
        end
        check("R6 no rise strobes while paused", rise_cnt - r0, 0);
        check("R6 no fall strobes while paused", fall_cnt - f0, 0);
    endtask

    initial begin
        int r0, f0;
        wait_clk(4);
        check("R10 paused after reset", paused, 0);
        check("R10 selected after reset", selected, 0);
        check("R10 so_oe after reset", so_oe, 0);
        check("R10 strobes after reset", {rise_en, fall_en}, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: pause input ignored while deselected.
        hold_n = 1'b0; wait_clk(HALF);
        check("R1 no pause while deselected", paused, 0);
        check("R7 so_oe off while deselected", so_oe, 0);
        hold_n = 1'b1; wait_clk(HALF);

        // Vector table: one byte per entry, one pause per byte.
        for (int v = 0; v < NV; v++) begin
            logic [7:0] byt;
            logic [2:0] pb;
            logic ehi, xhi;
            {byt, pb, ehi, xhi} = VEC[v];
            r0 = rise_cnt; f0 = fall_cnt;
            cs_n = 1'b0; wait_clk(HALF);
            check("R7 so_oe on when selected", so_oe, 1);
            for (int b = 0; b < 8; b++) begin
                si = byt[7-b]; sck = 1'b0; wait_clk(HALF);
                if (b == int'(pb) && !ehi) begin
                    hold_n = 1'b0; wait_clk(SETL);
                    check("R2 pause in low phase", paused, 1);
                    check("R7 so_oe off when paused", so_oe, 0);
                    pause_body(xhi);
                    si = byt[7-b];
                    wait_clk(HALF);
                end
                sck = 1'b1; wait_clk(HALF);
                if (b == int'(pb) && ehi) begin
                    hold_n = 1'b0; wait_clk(SETL);
                    check("R3 request in high phase deferred", paused, 0);
                    check("R7 so_oe off on pause fall in high phase", so_oe, 0);
                    sck = 1'b0; wait_clk(SETL);
                    check("R3 pause at falling edge", paused, 1);
                    pause_body(xhi);
                end
            end
            sck = 1'b0; wait_clk(HALF);
            check("R9 rise strobes per byte", rise_cnt - r0, 8);
            check("R9 fall strobes per byte (R3/R5 edge handling)", fall_cnt - f0, 8);
            check("R9 received byte", rx, byt);
            cs_n = 1'b1; wait_clk(HALF);
        end

        // R8: deselect in the middle of a pause.
        cs_n = 1'b0; wait_clk(HALF);
        si = 1'b1; sck = 1'b1; wait_clk(HALF);
        sck = 1'b0; wait_clk(HALF);
        hold_n = 1'b0; wait_clk(SETL);
        check("R8 paused before deselect", paused, 1);
        cs_n = 1'b1; wait_clk(SETL);
        check("R8 deselect clears pause", paused, 0);
        check("R8 deselect clears selected", selected, 0);
        hold_n = 1'b1; wait_clk(HALF);

        // New transfer after the aborted one runs unpaused.
        r0 = rise_cnt;
        cs_n = 1'b0; wait_clk(HALF);
        for (int b = 0; b < 8; b++) begin
            si = b[0]; sck = 1'b0; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
        end
        sck = 1'b0; wait_clk(HALF);
        check("R8 fresh transfer after deselect", rx, 8'h55);
        check("R9 rise count after deselect", rise_cnt - r0, 8);
        cs_n = 1'b1; wait_clk(HALF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule